// File: doc/BRIEF.md
# Configurable Sum-of-Products Function Block

This block is one logic function block of a small complex programmable logic device. It takes a set of signal inputs, forms product terms in a programmable AND array, and gathers those terms into the OR sums of a row of macrocells. Each macrocell owns a small group of terms. When a macrocell needs more terms than it owns, it can take unused ones from either adjacent macrocell, so one output can realise a wider sum. Each macrocell then applies a polarity bit and, if configured, a register on a global clock. A global set/reset loads each register with a configured value. Each output has its own enable, and a global three-state control overrides all of them.

The configuration arrives on static buses and is expected to hold still during operation. Every count is a parameter, so that a reduced instance can be checked against a software model. The block has no streaming interface and no handshake: inputs are sampled combinationally or on the clock, and all pins are plain level signals.

Top module: `cfb_top`

## Requirements
- R1: Product term t uses configuration bits `cfg_and[t*2*N_IN +: 2*N_IN]`. Within that field, bit 2i selects input i in true form and bit 2i+1 selects it in complemented form. The term is the AND of all the literals it selects. Term t belongs to macrocell t / N_PT, as its slot t % N_PT.
- R2: A product term that selects no literals evaluates to 0 for every input pattern.
- R3: A macrocell's sum includes each of its own terms whose `cfg_keep` bit is 1. A term whose keep bit is 0 and that no neighbour takes contributes to no sum.
- R4: `cfg_bl[m*N_PT+k]` makes macrocell m take slot k of macrocell m-1, and `cfg_br[m*N_PT+k]` makes it take slot k of macrocell m+1. A term taken this way adds to the taker's sum and is absent from its owner's sum.
- R5: A term whose keep bit is 1 stays with its owner, and a neighbour's request for it has no effect.
- R6: When both neighbours request the same unkept term, the lower-numbered macrocell receives it and the other receives nothing from it.
- R7: A request from macrocell 0 toward a lower neighbour, or from the last macrocell toward a higher one, has no effect. There is no wrap-around.
- R8: `cfg_pol[m]` = 1 inverts the macrocell's sum before the register and the output, and 0 passes it unchanged.
- R9: With `cfg_reg[m]` = 1, the output shows a register that captures the polarity-adjusted sum on each rising clock edge and holds it between edges.
- R10: While `gsr` is high, every register holds `cfg_rst[m]`. Raising `gsr` loads that value at once, without a clock edge, and the clock has no effect while `gsr` is high.
- R11: `dout_oe[m]` is 1 only when `mc_oe[m]` is 1 and `gts` is 0. Whenever `dout_oe[m]` is 0, `dout[m]` is 0.
- R12: With `cfg_reg[m]` = 0, the output follows the inputs combinationally, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for all macrocell registers |
| gsr | input | 1 | Global set/reset, asynchronous, active high |
| gts | input | 1 | Global three-state control, active high |
| din | input | N_IN | Signal inputs to the AND array |
| mc_oe | input | N_MC | Per-macrocell output enable request |
| cfg_and | input | N_MC*N_PT*2*N_IN | Literal selection bits, one field per term |
| cfg_keep | input | N_MC*N_PT | Owner keeps term in its own sum |
| cfg_bl | input | N_MC*N_PT | Request term slot from lower neighbour |
| cfg_br | input | N_MC*N_PT | Request term slot from higher neighbour |
| cfg_pol | input | N_MC | Output inversion per macrocell |
| cfg_reg | input | N_MC | Registered (1) or combinational (0) per macrocell |
| cfg_rst | input | N_MC | Value loaded by global set/reset |
| dout | output | N_MC | Macrocell outputs, 0 when not enabled |
| dout_oe | output | N_MC | Effective output enables |

## Verification
The bench builds the block with 3 inputs, 4 macrocells and 2 terms per macrocell. At this size every input pattern can be swept. Both edge macrocells and both interior macrocells are present, so a term can be requested from both sides at once, and a request off either end can be posed against a term that a wrap-around would reach. Two terms per macrocell make it possible to lend one slot while keeping the other.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  typedef struct packed {
    logic pol;
    logic regm;
    logic rstv;
  } mc_cfg_t;

  function automatic int term_base(input int mc, input int slot, input int n_pt);
    return mc * n_pt + slot;
  endfunction
endpackage

// File: rtl/cfb_and_array.sv
module cfb_and_array #(
  parameter int N_IN   = 36,
  parameter int N_TERM = 90,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]         din,
  input  logic [N_TERM*N_LIT-1:0] cfg_and,
  output logic [N_TERM-1:0]       term
);
  logic [N_LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = din[i];
    assign lit[2*i+1] = ~din[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_LIT-1:0] sel;
    assign sel     = cfg_and[t*N_LIT +: N_LIT];
    // an empty selection must not yield a vacuous 1
    assign term[t] = (|sel) & (&(~sel | lit));
  end
endmodule

// File: rtl/cfb_pt_alloc.sv
module cfb_pt_alloc #(
  parameter int N_MC = 18,
  parameter int N_PT = 5,
  localparam int N_TERM = N_MC * N_PT
) (
  input  logic [N_TERM-1:0] term,
  input  logic [N_TERM-1:0] cfg_keep,
  input  logic [N_TERM-1:0] cfg_bl,
  input  logic [N_TERM-1:0] cfg_br,
  output logic [N_TERM-1:0] g_own,
  output logic [N_TERM-1:0] g_lo,
  output logic [N_TERM-1:0] g_hi,
  output logic [N_MC-1:0]   sum
);
  import cfb_pkg::*;

  for (genvar j = 0; j < N_MC; j++) begin : g_owner
    for (genvar k = 0; k < N_PT; k++) begin : g_slot
      localparam int T = j * N_PT + k;
      logic req_lo, req_hi;
      if (j > 0) begin : g_has_lo
        assign req_lo = cfg_br[(j-1)*N_PT + k];
      end else begin : g_no_lo
        assign req_lo = 1'b0;
      end
      if (j < N_MC - 1) begin : g_has_hi
        assign req_hi = cfg_bl[(j+1)*N_PT + k];
      end else begin : g_no_hi
        assign req_hi = 1'b0;
      end
      // owner first, then the lower-numbered neighbour
      assign g_own[T] = cfg_keep[T];
      assign g_lo[T]  = ~cfg_keep[T] & req_lo;
      assign g_hi[T]  = ~cfg_keep[T] & ~req_lo & req_hi;
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_sum
    localparam int B = term_base(m, 0, N_PT);
    logic own_part, from_lo, from_hi;
    assign own_part = |(term[B +: N_PT] & g_own[B +: N_PT]);
    if (m > 0) begin : g_lo_src
      assign from_lo = |(term[B-N_PT +: N_PT] & g_hi[B-N_PT +: N_PT]);
    end else begin : g_lo_none
      assign from_lo = 1'b0;
    end
    if (m < N_MC - 1) begin : g_hi_src
      assign from_hi = |(term[B+N_PT +: N_PT] & g_lo[B+N_PT +: N_PT]);
    end else begin : g_hi_none
      assign from_hi = 1'b0;
    end
    assign sum[m] = own_part | from_lo | from_hi;
  end
endmodule

// File: rtl/cfb_macrocell.sv
module cfb_macrocell
  import cfb_pkg::*;
(
  input  logic    clk,
  input  logic    gsr,
  input  logic    gts,
  input  logic    sum,
  input  mc_cfg_t cfg,
  input  logic    oe_req,
  output logic    q,
  output logic    dout,
  output logic    doe
);
  logic d;
  logic core;

  assign d = sum ^ cfg.pol;

  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) q <= cfg.rstv;
    else     q <= d;
  end

  assign core = cfg.regm ? q : d;
  assign doe  = oe_req & ~gts;
  assign dout = doe & core;
endmodule

// File: rtl/cfb_top.sv
module cfb_top
  import cfb_pkg::*;
#(
  parameter int N_IN = 36,
  parameter int N_MC = 18,
  parameter int N_PT = 5,
  localparam int N_TERM = N_MC * N_PT,
  localparam int N_LIT  = 2 * N_IN,
  localparam int AND_W  = N_TERM * N_LIT
) (
  input  logic              clk,
  input  logic              gsr,
  input  logic              gts,
  input  logic [N_IN-1:0]   din,
  input  logic [N_MC-1:0]   mc_oe,
  input  logic [AND_W-1:0]  cfg_and,
  input  logic [N_TERM-1:0] cfg_keep,
  input  logic [N_TERM-1:0] cfg_bl,
  input  logic [N_TERM-1:0] cfg_br,
  input  logic [N_MC-1:0]   cfg_pol,
  input  logic [N_MC-1:0]   cfg_reg,
  input  logic [N_MC-1:0]   cfg_rst,
  output logic [N_MC-1:0]   dout,
  output logic [N_MC-1:0]   dout_oe
);
  logic [N_TERM-1:0] term_w;
  logic [N_TERM-1:0] g_own, g_lo, g_hi;
  logic [N_MC-1:0]   sum_w;
  logic [N_MC-1:0]   q_w;

  cfb_and_array #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din(din), .cfg_and(cfg_and), .term(term_w)
  );

  cfb_pt_alloc #(.N_MC(N_MC), .N_PT(N_PT)) u_alloc (
    .term(term_w), .cfg_keep(cfg_keep), .cfg_bl(cfg_bl), .cfg_br(cfg_br),
    .g_own(g_own), .g_lo(g_lo), .g_hi(g_hi), .sum(sum_w)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    mc_cfg_t mcfg;
    assign mcfg = '{pol: cfg_pol[m], regm: cfg_reg[m], rstv: cfg_rst[m]};
    cfb_macrocell u_mc (
      .clk(clk), .gsr(gsr), .gts(gts), .sum(sum_w[m]), .cfg(mcfg),
      .oe_req(mc_oe[m]), .q(q_w[m]), .dout(dout[m]), .doe(dout_oe[m])
    );
  end
endmodule

// File: rtl/cfb_chk.sv
module cfb_chk #(
  parameter int N_MC = 18,
  parameter int N_PT = 5,
  localparam int N_TERM = N_MC * N_PT
) (
  input logic              clk,
  input logic              gsr,
  input logic              gts,
  input logic [N_MC-1:0]   dout,
  input logic [N_MC-1:0]   dout_oe,
  input logic [N_MC-1:0]   cfg_pol,
  input logic [N_MC-1:0]   cfg_rst,
  input logic [N_MC-1:0]   sum,
  input logic [N_MC-1:0]   q,
  input logic [N_TERM-1:0] g_own,
  input logic [N_TERM-1:0] g_lo,
  input logic [N_TERM-1:0] g_hi
);
  logic primed;

  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    assert_single_owner_R6: assert property (@(posedge clk) disable iff (gsr)
      $onehot0({g_own[t], g_lo[t], g_hi[t]}));
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_m
    assert_reg_capture_R9: assert property (@(posedge clk) disable iff (gsr)
      primed |-> (q[m] == $past(sum[m] ^ cfg_pol[m])));
  end

  always @(negedge clk) begin
    if (gsr) begin
      assert_reset_load_R10: assert (q == cfg_rst);
    end
  end

  assert_tristate_R11: assert property (@(posedge clk) disable iff (gsr)
    gts |-> (dout_oe == '0));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (gsr)
    ((dout & ~dout_oe) == '0));
endmodule

bind cfb_top cfb_chk #(.N_MC(N_MC), .N_PT(N_PT)) u_chk (
  .clk(clk), .gsr(gsr), .gts(gts), .dout(dout), .dout_oe(dout_oe),
  .cfg_pol(cfg_pol), .cfg_rst(cfg_rst), .sum(sum_w), .q(q_w),
  .g_own(g_own), .g_lo(g_lo), .g_hi(g_hi)
);

// File: tb/sim_cfb_top.sv
`timescale 1ns/1ps
module sim_cfb_top;
  localparam int P_IN = 3;
  localparam int P_MC = 4;
  localparam int P_PT = 2;
  localparam int P_T  = P_MC * P_PT;
  localparam int P_L  = 2 * P_IN;

  logic clk = 1'b0;
  logic gsr = 1'b0;
  logic gts = 1'b0;
  logic [P_IN-1:0]   din = '0;
  logic [P_MC-1:0]   mc_oe = '1;
  logic [P_T*P_L-1:0] cfg_and = '0;
  logic [P_T-1:0]    cfg_keep = '0, cfg_bl = '0, cfg_br = '0;
  logic [P_MC-1:0]   cfg_pol = '0, cfg_reg = '0, cfg_rst = '0;
  logic [P_MC-1:0]   dout, dout_oe;
  logic [P_MC-1:0]   mq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfb_top #(.N_IN(P_IN), .N_MC(P_MC), .N_PT(P_PT)) u0 (
    .clk(clk), .gsr(gsr), .gts(gts), .din(din), .mc_oe(mc_oe),
    .cfg_and(cfg_and), .cfg_keep(cfg_keep), .cfg_bl(cfg_bl), .cfg_br(cfg_br),
    .cfg_pol(cfg_pol), .cfg_reg(cfg_reg), .cfg_rst(cfg_rst),
    .dout(dout), .dout_oe(dout_oe)
  );

  // ---- model built from the requirements ----
  function automatic logic m_term(input int t);
    logic [P_L-1:0] sel, lit;
    for (int i = 0; i < P_IN; i++) begin
      lit[2*i] = din[i];
      lit[2*i+1] = ~din[i];
    end
    sel = cfg_and[t*P_L +: P_L];
    return (sel != 0) && ((sel & ~lit) == 0);
  endfunction

  function automatic logic m_sum(input int m);
    logic s = 1'b0;
    for (int k = 0; k < P_PT; k++) begin
      if (cfg_keep[m*P_PT+k] && m_term(m*P_PT+k)) s = 1'b1;
      if (m > 0 && cfg_bl[m*P_PT+k] && !cfg_keep[(m-1)*P_PT+k]
          && !(m > 1 && cfg_br[(m-2)*P_PT+k]) && m_term((m-1)*P_PT+k)) s = 1'b1;
      if (m < P_MC-1 && cfg_br[m*P_PT+k] && !cfg_keep[(m+1)*P_PT+k]
          && m_term((m+1)*P_PT+k)) s = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [P_MC-1:0] m_oe();
    return mc_oe & {P_MC{~gts}};
  endfunction

  function automatic logic [P_MC-1:0] m_dout();
    logic [P_MC-1:0] r;
    for (int m = 0; m < P_MC; m++)
      r[m] = m_oe()[m] & (cfg_reg[m] ? mq[m] : (m_sum(m) ^ cfg_pol[m]));
    return r;
  endfunction

  always @(posedge clk or posedge gsr) begin
    if (gsr) mq <= cfg_rst;
    else for (int m = 0; m < P_MC; m++) mq[m] <= m_sum(m) ^ cfg_pol[m];
  end

  // ---- helpers ----
  task automatic chk(input string req, input logic [P_MC-1:0] act, input logic [P_MC-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    cfg_and = '0; cfg_keep = '0; cfg_bl = '0; cfg_br = '0;
    cfg_pol = '0; cfg_reg = '0; mc_oe = '1; gts = 1'b0; din = '0;
  endtask

  task automatic sel_lit(input int m, input int k, input int l);
    cfg_and[(m*P_PT+k)*P_L + l] = 1'b1;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < (1 << P_IN); v++) begin
      @(negedge clk);
      din = v[P_IN-1:0];
      #1;
      chk(req, dout, m_dout());
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    cfg_reg = '1; cfg_rst = 4'b1010; mc_oe = '1;
    #1 gsr = 1'b1;
    #2;
    chk("R10 reset load", dout, 4'b1010);
    chk("R11 reset oe", dout_oe, 4'b1111);
    @(negedge clk);
    gsr = 1'b0;
  endtask

  task automatic t_literals();
    clear_cfg();
    sel_lit(0, 0, 0); sel_lit(0, 0, 3); cfg_keep[0] = 1'b1;
    @(negedge clk); din = 3'b001; #1;
    chk("R1 true/compl hit", dout, 4'b0001);
    @(negedge clk); din = 3'b011; #1;
    chk("R1 compl miss", dout, 4'b0000);
    sweep("R1 sweep");
  endtask

  task automatic t_empty();
    clear_cfg();
    cfg_keep[1*P_PT] = 1'b1;
    sweep("R2 empty term");
    @(negedge clk); din = 3'b111; #1;
    chk("R2 empty all ones", dout, 4'b0000);
  endtask

  task automatic t_or();
    clear_cfg();
    sel_lit(2, 0, 0); sel_lit(2, 1, 4);
    cfg_keep[2*P_PT] = 1'b1; cfg_keep[2*P_PT+1] = 1'b1;
    @(negedge clk); din = 3'b100; #1;
    chk("R3 or second term", dout, 4'b0100);
    sweep("R3 sweep");
  endtask

  task automatic t_borrow();
    clear_cfg();
    sel_lit(0, 0, 0); sel_lit(2, 1, 2);
    cfg_bl[1*P_PT+0] = 1'b1; cfg_br[1*P_PT+1] = 1'b1;
    @(negedge clk); din = 3'b001; #1;
    chk("R4 from lower", dout, 4'b0010);
    @(negedge clk); din = 3'b010; #1;
    chk("R4 from higher", dout, 4'b0010);
    sweep("R4 sweep");
  endtask

  task automatic t_owner();
    clear_cfg();
    sel_lit(0, 0, 0); sel_lit(2, 1, 2);
    cfg_bl[1*P_PT+0] = 1'b1; cfg_br[1*P_PT+1] = 1'b1;
    cfg_keep[0] = 1'b1;
    @(negedge clk); din = 3'b001; #1;
    chk("R5 owner keeps", dout, 4'b0001);
    sweep("R5 sweep");
  endtask

  task automatic t_conflict();
    clear_cfg();
    sel_lit(1, 0, 4);
    cfg_br[0*P_PT+0] = 1'b1; cfg_bl[2*P_PT+0] = 1'b1;
    @(negedge clk); din = 3'b100; #1;
    chk("R6 lower wins", dout, 4'b0001);
    sweep("R6 sweep");
  endtask

  task automatic t_edge();
    clear_cfg();
    sel_lit(3, 0, 0); sel_lit(0, 0, 2);
    cfg_bl[0] = 1'b1; cfg_br[3*P_PT+0] = 1'b1;
    @(negedge clk); din = 3'b011; #1;
    chk("R7 no wrap", dout, 4'b0000);
    sweep("R7 sweep");
  endtask

  task automatic t_polarity();
    clear_cfg();
    sel_lit(0, 0, 0); cfg_keep[0] = 1'b1; cfg_pol[0] = 1'b1;
    @(negedge clk); din = 3'b000; #1;
    chk("R8 inverted low", dout, 4'b1111 & {3'b000, 1'b1} | 4'b0000);
    @(negedge clk); din = 3'b001; #1;
    chk("R8 inverted high", dout, 4'b0000);
  endtask

  task automatic t_registered();
    clear_cfg();
    sel_lit(3, 0, 0); cfg_keep[3*P_PT] = 1'b1; cfg_reg[3] = 1'b1;
    sel_lit(2, 0, 0); cfg_keep[2*P_PT] = 1'b1;
    @(posedge clk); @(negedge clk);
    din = 3'b001; #1;
    chk("R12 comb immediate, R9 reg holds", dout, 4'b0100);
    @(posedge clk); #1;
    chk("R9 captured", dout, 4'b1100);
    @(negedge clk); din = 3'b000; #1;
    chk("R9 holds between edges", dout, 4'b1000);
    @(posedge clk); #1;
    chk("R9 captured zero", dout, 4'b0000);
  endtask

  task automatic t_gsr_async();
    clear_cfg();
    sel_lit(3, 0, 0); cfg_keep[3*P_PT] = 1'b1; cfg_reg[3] = 1'b1;
    cfg_rst = 4'b0000;
    din = 3'b001;
    @(posedge clk); #1;
    chk("R9 preload", dout, 4'b1000);
    #2 gsr = 1'b1;
    #1;
    chk("R10 async load", dout, 4'b0000);
    @(posedge clk); #1;
    chk("R10 clock ignored", dout, 4'b0000);
    @(negedge clk); gsr = 1'b0;
    @(posedge clk); #1;
    chk("R10 released", dout, 4'b1000);
  endtask

  task automatic t_enable();
    clear_cfg();
    cfg_pol = 4'b1111;
    @(negedge clk); mc_oe = 4'b1110; #1;
    chk("R11 own enable dout", dout, 4'b1110);
    chk("R11 own enable oe", dout_oe, 4'b1110);
    @(negedge clk); gts = 1'b1; #1;
    chk("R11 gts dout", dout, 4'b0000);
    chk("R11 gts oe", dout_oe, 4'b0000);
    chk("R11 model", dout, m_dout());
    @(negedge clk); gts = 1'b0; mc_oe = '1; #1;
    chk("R11 restored", dout_oe, 4'b1111);
  endtask

  initial begin
    t_reset();
    t_literals();
    t_empty();
    t_or();
    t_borrow();
    t_owner();
    t_conflict();
    t_edge();
    t_polarity();
    t_registered();
    t_gsr_async();
    t_enable();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule